// File: doc/BRIEF.md
# Video DMA Channel Control and Status Registers

This block is the register front end of one video DMA channel. Software writes one 32-bit control word that sets run/stop, circular mode, genlock, frame-count enable, frame-sync source, the genlock master select, three interrupt enables, a frame coalescing count and a delay count. Software reads a 32-bit status word. It holds the halted and idle indications, sticky error flags, three interrupt flags, the running frame count and the running delay count. The data movers are outside this block. They report frame completion, error events and an idle indication on plain pulse and level pins.

The control logic turns run/stop into a halted acknowledgement and a run qualifier for the movers. It runs a fixed-length soft reset that clears its own request bit. It counts finished frames so that the frame interrupt fires once per programmed group of frames. While frames are counted but the group is not yet complete, a timer raises a delay interrupt. Interrupt flags are cleared by writing 1. Only the recoverable error flags can be cleared by software, and only when flush-on-frame-sync is built in. Every other error flag holds until a soft or hard reset.

The register port is a single-cycle strobe with a word select (0 = control, 1 = status) and a combinational read path. There is no back-pressure on any pin.

Top module: `vchan_csr_block`

## Requirements
- R1: After hard reset, the control word reads 0x00000000 and the status word reads 0x00000001 with bit 1 equal to `dp_idle`. `irq` and `dp_run` are 0.
- R2: A control write stores bits 0,1,3-6, 8-11, 12-14 and 16-31. Bits 2 (when no reset is running), 7 and 15 read 0, so writing 0xFFFFFFFB reads back 0xFFFF7F7B.
- R3: Status bit 0 (halted) clears on the clock edge after control bit 0 (run) reads 1. It sets on the first edge at which run reads 0 and `dp_idle` is high. `dp_run` is high only while halted is clear and no soft reset is running.
- R4: Writing control bit 2 starts a soft reset, and the other bits of that write are ignored. Bit 2 reads 1 for exactly 8 cycles, and register writes in that window are ignored. At the end, the control word, the error and interrupt flags and both counters are zero, and halted is set.
- R5: While running, each `frame_done` pulse advances the frame count in status bits 23:16. When the count reaches the coalescing value in control bits 23:16, status bit 12 sets and the count reloads to 0.
- R6: A coalescing value of 0 acts as 1: every counted frame sets status bit 12, and the count stays 0.
- R7: With a nonzero delay D in control bits 31:24 and at least one frame counted, status bits 31:24 count cycles since the last frame. Status bit 13 sets D edges after the frame edge, and the count restarts at 0.
- R8: An error pulse on `err_evt[i]` sets a sticky status bit. Indexes 0-7 map to status bits 4-11, and index 8 maps to bit 15. Any error pulse also sets status bit 14.
- R9: Writing 1 to status bits 12, 13 or 14 clears that flag. Writing 0 leaves it unchanged. A flag set in the same cycle wins over the clear.
- R10: A status write of 1 clears error bits 4, 7, 8 and 11 only. Bits 5, 6, 9, 10 and 15 stay set until soft or hard reset.
- R11: `irq` is high exactly when some status flag 12/13/14 is set and its enable in the control bit at the same position is set.
- R12: `frame_done` while halted is not counted and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| csr_wr | input | 1 | Register write strobe, one cycle |
| csr_sel | input | 1 | Word select: 0 control, 1 status |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected word |
| frame_done | input | 1 | One pulse per finished frame |
| err_evt | input | 9 | Error event pulses, one per error kind |
| dp_idle | input | 1 | Data movers have no transfer in flight |
| dp_run | output | 1 | Movers may run |
| irq | output | 1 | Channel interrupt |

## Verification
The frame coalescer is swept over the coalescing values 1 to 5 and the value 0. This shows whether the flag fires on exactly the Nth frame and whether the reload returns the count to 0 rather than 1. The delay timer is tried with delays of 1, 3 and 6 cycles, which separates an off-by-one at the terminal count from a correct timer. Every control bit is written alone to expose a wrong writable mask. Every error input is pulsed alone and then cleared all at once, which tells a recoverable bit from a sticky one. The soft reset is sampled on each cycle of its window, with a write injected in the middle.

// File: rtl/vchan_csr_pkg.sv
package vchan_csr_pkg;
  localparam int WORD_W   = 32;
  localparam int N_ERR    = 9;
  localparam int CNT_W    = 8;

  // control word positions
  localparam int C_RUN    = 0;
  localparam int C_SRST   = 2;
  localparam int C_IE_LO  = 12;
  localparam int C_COAL   = 16;
  localparam int C_DLY    = 24;

  // status word positions
  localparam int S_HALT   = 0;
  localparam int S_IDLE   = 1;
  localparam int S_FLG_LO = 12;
  localparam int S_FCNT   = 16;
  localparam int S_DCNT   = 24;

  // error indexes that software may clear: internal, sof-early, eof-early, sof-late
  localparam logic [N_ERR-1:0] RECOV_IDX = 9'b010011001;

  function automatic int err_pos(input int idx);
    return (idx < 8) ? (4 + idx) : 15;
  endfunction
endpackage

// File: rtl/vchan_reset_seq.sv
module vchan_reset_seq #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (start && cnt_q == 0) cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != 0)          cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);
  assign done = (cnt_q == CW'(1));

  // R4: the sequence ends on the edge after its last busy cycle
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/vchan_frame_coalesce.sv
module vchan_frame_coalesce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] coalesce,
  input  logic [CNT_W-1:0] delay,
  output logic             frm_hit,
  output logic             dly_hit,
  output logic [CNT_W-1:0] frm_cnt,
  output logic [CNT_W-1:0] dly_cnt
);
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   frm_nxt, dly_nxt;
  logic             timing;

  assign target  = (coalesce == 0) ? CNT_W'(1) : coalesce;
  assign frm_nxt = {1'b0, frm_cnt} + 1'b1;
  assign dly_nxt = {1'b0, dly_cnt} + 1'b1;
  assign timing  = active && (delay != 0) && (frm_cnt != 0) && !frame_done;
  assign frm_hit = active && frame_done && (frm_nxt >= {1'b0, target});
  assign dly_hit = timing && (dly_nxt == {1'b0, delay});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_cnt <= '0;
      dly_cnt <= '0;
    end else if (clr) begin
      frm_cnt <= '0;
      dly_cnt <= '0;
    end else if (active && frame_done) begin
      frm_cnt <= frm_hit ? '0 : frm_nxt[CNT_W-1:0];
      dly_cnt <= '0;
    end else if (dly_hit || !timing) begin
      dly_cnt <= '0;
    end else begin
      dly_cnt <= dly_nxt[CNT_W-1:0];
    end
  end

  // R5 R6: a completed group reloads the frame count to zero
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_hit && !clr) |=> (frm_cnt == 0));
  // R7: the delay timer restarts when it expires
  a_r7_dly_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_hit && !clr) |=> (dly_cnt == 0));
endmodule

// File: rtl/vchan_status_flags.sv
module vchan_status_flags
  import vchan_csr_pkg::*;
#(
  parameter bit FLUSH_ON_FSYNC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              frm_hit,
  input  logic              dly_hit,
  input  logic              w1c_en,
  input  logic [15:0]       w1c_data,
  input  logic [2:0]        irq_en,
  output logic [15:0]       flag_word,
  output logic              irq
);
  localparam logic [N_ERR-1:0] FATAL = FLUSH_ON_FSYNC ? ~RECOV_IDX : '1;

  logic [N_ERR-1:0] err_q;
  logic [2:0]       flg_q;
  logic [2:0]       flg_set;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    localparam int P = err_pos(g);
    logic clr_ok;
    assign clr_ok = FLUSH_ON_FSYNC && RECOV_IDX[g] && w1c_en && w1c_data[P];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err_q[g] <= 1'b0;
      else if (clr)        err_q[g] <= 1'b0;
      else if (err_evt[g]) err_q[g] <= 1'b1;
      else if (clr_ok)     err_q[g] <= 1'b0;
    end
  end

  assign flg_set = {|err_evt, dly_hit, frm_hit};

  for (genvar f = 0; f < 3; f++) begin : g_flg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 flg_q[f] <= 1'b0;
      else if (clr)                               flg_q[f] <= 1'b0;
      else if (flg_set[f])                        flg_q[f] <= 1'b1;
      else if (w1c_en && w1c_data[S_FLG_LO + f])  flg_q[f] <= 1'b0;
    end
  end

  always_comb begin
    flag_word = '0;
    for (int i = 0; i < N_ERR; i++) flag_word[err_pos(i)] = err_q[i];
    flag_word[S_FLG_LO +: 3] = flg_q;
  end

  assign irq = |(flg_q & irq_en);

  // R10: non-recoverable errors never clear except through reset
  a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q) & FATAL) == ($past(err_q) & FATAL)));
  // R5: the frame flag only rises after a completed group
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[0]) |-> $past(frm_hit));
  // R8: the error flag only rises after an error event
  a_r8_err_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[2]) |-> $past(|err_evt));
endmodule

// File: rtl/vchan_csr_block.sv
module vchan_csr_block
  import vchan_csr_pkg::*;
#(
  parameter int RST_CYCLES     = 8,
  parameter bit FLUSH_ON_FSYNC = 1'b1,
  parameter int MASTER_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_sel,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              frame_done,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              dp_idle,
  output logic              dp_run,
  output logic              irq
);
  localparam logic [WORD_W-1:0] CTRL_MASK =
    32'hFFFF_707B | (((32'd1 << MASTER_W) - 32'd1) << 8);

  logic [WORD_W-1:0] ctrl_q;
  logic              halted_q;
  logic              rst_busy, rst_done, rst_start;
  logic              wr_ctrl, wr_stat, active;
  logic              frm_hit, dly_hit;
  logic [CNT_W-1:0]  frm_cnt, dly_cnt;
  logic [15:0]       flag_word;
  logic [WORD_W-1:0] stat_word;

  assign wr_ctrl   = csr_wr && !csr_sel && !rst_busy;
  assign wr_stat   = csr_wr &&  csr_sel && !rst_busy;
  assign rst_start = wr_ctrl && csr_wdata[C_SRST];
  assign active    = !halted_q && !rst_busy;
  assign dp_run    = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      halted_q <= 1'b1;
    end else if (rst_done) begin
      ctrl_q   <= '0;
      halted_q <= 1'b1;
    end else begin
      if (wr_ctrl && !csr_wdata[C_SRST]) ctrl_q <= csr_wdata & CTRL_MASK;
      if (ctrl_q[C_RUN])                 halted_q <= 1'b0;
      else if (dp_idle)                  halted_q <= 1'b1;
    end
  end

  vchan_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(rst_busy), .done(rst_done)
  );

  vchan_frame_coalesce #(.CNT_W(CNT_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .clr(rst_done), .active(active),
    .frame_done(frame_done),
    .coalesce(ctrl_q[C_COAL +: CNT_W]), .delay(ctrl_q[C_DLY +: CNT_W]),
    .frm_hit(frm_hit), .dly_hit(dly_hit), .frm_cnt(frm_cnt), .dly_cnt(dly_cnt)
  );

  vchan_status_flags #(.FLUSH_ON_FSYNC(FLUSH_ON_FSYNC)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(rst_done), .err_evt(err_evt),
    .frm_hit(frm_hit), .dly_hit(dly_hit), .w1c_en(wr_stat),
    .w1c_data(csr_wdata[15:0]), .irq_en(ctrl_q[C_IE_LO +: 3]),
    .flag_word(flag_word), .irq(irq)
  );

  always_comb begin
    stat_word                  = {16'h0, flag_word};
    stat_word[S_HALT]          = halted_q;
    stat_word[S_IDLE]          = dp_idle;
    stat_word[S_FCNT +: CNT_W] = frm_cnt;
    stat_word[S_DCNT +: CNT_W] = dly_cnt;
  end

  assign csr_rdata = csr_sel ? stat_word
                             : (ctrl_q | (WORD_W'(rst_busy) << C_SRST));

  // R3: a stopped, idle channel reports halted on the next edge
  a_r3_halt_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[C_RUN] && dp_idle && !rst_busy) |=> halted_q);
  // R3: a running request is acknowledged on the next edge
  a_r3_run_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_RUN] && !rst_busy) |=> !halted_q);
  // R4: completing a soft reset leaves the control word empty
  a_r4_ctrl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> (ctrl_q == '0 && halted_q));
endmodule

// File: tb/vchan_csr_block_bench.sv
module vchan_csr_block_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic        csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        frame_done = 1'b0;
  logic [8:0]  err_evt = '0;
  logic        dp_idle = 1'b1;
  logic        dp_run, irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  vchan_csr_block u_vchan_csr_block (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .frame_done(frame_done),
    .err_evt(err_evt), .dp_idle(dp_idle), .dp_run(dp_run), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
    step(1);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    csr_sel = sel; #1; v = csr_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_frame(input int n);
    frame_done = 1'b1; step(n); frame_done = 1'b0;
  endtask

  function automatic int epos(input int i);
    return (i < 8) ? 4 + i : 15;
  endfunction

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] acc;
    step(3); rst_n = 1'b1; step(1);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'h0);
    rd(1, v); chk("R1 status", v, 32'h3);
    chk("R1 irq/run", {30'b0, irq, dp_run}, 32'h0);

    // R2 writable mask, all bits and each bit alone
    wr(0, 32'hFFFF_FFFB); rd(0, v); chk("R2 all", v, 32'hFFFF_7F7B);
    for (int i = 0; i < 32; i++) begin
      if (i != 2) begin
        wr(0, 32'h1 << i); rd(0, v);
        chk($sformatf("R2 bit%0d", i), v, (32'h1 << i) & 32'hFFFF_7F7B);
      end
    end
    wr(0, 32'h0); step(1);

    // R3 run/halt handshake
    wr(0, 32'h1); rd(1, v); chk("R3 still halted", v & 32'h1, 32'h1);
    step(1); rd(1, v); chk("R3 halted cleared", v & 32'h1, 32'h0);
    chk("R3 dp_run", {31'b0, dp_run}, 32'h1);
    dp_idle = 1'b0; wr(0, 32'h0); step(3);
    rd(1, v); chk("R3 busy keeps running", v & 32'h1, 32'h0);
    dp_idle = 1'b1; step(1);
    rd(1, v); chk("R3 halted after idle", v & 32'h1, 32'h1);
    chk("R3 dp_run low", {31'b0, dp_run}, 32'h0);

    // R5 R11 coalescing sweep
    for (int n = 1; n <= 5; n++) begin
      wr(0, 32'h1 | (32'h1 << 12) | (n << 16)); step(1);
      wr(1, 32'h7000);
      for (int k = 1; k <= n; k++) begin
        pulse_frame(1);
        rd(1, v);
        chk($sformatf("R5 n%0d k%0d count", n, k), (v >> 16) & 32'hFF, k % n);
        chk($sformatf("R5 n%0d k%0d flag", n, k), (v >> 12) & 32'h1, (k == n));
        chk($sformatf("R11 n%0d k%0d irq", n, k), {31'b0, irq}, (k == n));
      end
    end

    // R6 coalescing value zero
    wr(0, 32'h1 | (32'h1 << 12)); wr(1, 32'h7000);
    for (int k = 0; k < 2; k++) begin
      pulse_frame(1); rd(1, v);
      chk("R6 flag", (v >> 12) & 32'h1, 32'h1);
      chk("R6 count", (v >> 16) & 32'hFF, 32'h0);
      if (k == 0) wr(1, 32'h1000);
    end

    // R9 write-one-to-clear
    wr(1, 32'h0); rd(1, v); chk("R9 zero keeps", (v >> 12) & 32'h1, 32'h1);
    chk("R11 irq with flag", {31'b0, irq}, 32'h1);
    wr(1, 32'h1000); rd(1, v); chk("R9 one clears", (v >> 12) & 32'h1, 32'h0);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);

    // R12 frames ignored while halted
    wr(0, 32'h0); step(1); wr(1, 32'h7000);
    pulse_frame(1); rd(1, v);
    chk("R12 halted no count", v & 32'h00FF_7000, 32'h0);

    // R7 delay timer sweep
    foreach (acc[i]) ; // no-op keeps acc declared use simple
    for (int t = 0; t < 3; t++) begin
      int d;
      d = (t == 0) ? 1 : (t == 1) ? 3 : 6;
      wr(0, 32'h1 | (32'h1 << 13) | (32'h4 << 16) | (d << 24)); step(1);
      wr(1, 32'h7000);
      pulse_frame(1);
      for (int j = 1; j < d; j++) begin
        step(1); rd(1, v);
        chk($sformatf("R7 d%0d j%0d count", d, j), v >> 24, j);
        chk($sformatf("R7 d%0d j%0d flag", d, j), (v >> 13) & 32'h1, 32'h0);
      end
      step(1); rd(1, v);
      chk($sformatf("R7 d%0d flag", d), (v >> 13) & 32'h1, 32'h1);
      chk($sformatf("R7 d%0d restart", d), v >> 24, 32'h0);
      chk($sformatf("R11 d%0d irq", d), {31'b0, irq}, 32'h1);
      pulse_frame(3);
      wr(1, 32'h7000);
    end

    // R8 error pulses
    wr(0, 32'h1 | (32'h1 << 14)); wr(1, 32'h7000);
    acc = '0;
    for (int i = 0; i < 9; i++) begin
      err_evt = 9'h1 << i; step(1); err_evt = '0;
      acc |= 32'h1 << epos(i);
      rd(1, v);
      chk($sformatf("R8 err%0d", i), v & 32'hFFF0, acc | 32'h4000);
    end
    chk("R11 err irq", {31'b0, irq}, 32'h1);

    // R10 only recoverable errors clear
    wr(1, 32'hFFFF_FFFF); rd(1, v);
    chk("R10 fatal remain", v & 32'hFFF0, 32'h8660);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);

    // R4 soft reset
    wr(0, 32'h0003_1001);
    wr(0, 32'h0000_0004);
    for (int j = 0; j < 8; j++) begin
      rd(0, v); chk($sformatf("R4 busy cyc%0d", j), v, 32'h0003_1005);
      if (j == 3) wr(0, 32'h00FF_0001);
      else        step(1);
    end
    rd(0, v); chk("R4 ctrl cleared", v, 32'h0);
    rd(1, v); chk("R4 status cleared", v, 32'h3);
    chk("R1 outputs after reset", {30'b0, irq, dp_run}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule